// File: doc/BRIEF.md
# Register Access Command Channel

This block is the command stage between a host register port and the serial engine that reaches an external power-management chip. Software writes one 32-bit command word. The block decodes the word as a read or a write and hands it to the serial back-end over a request/acknowledge interface. It then follows the transfer through a small state machine. The state, a pending flag, link idleness, an init-done bit and the latest read data are all packed into one status word that software polls.

A read does not return to idle by itself. It parks in a wait-for-valid-clear state with the data held in the status word, until software writes 1 to the valid-clear input. If the data arrives after software has given up waiting, the machine is stranded in that state. A valid-clear write then recovers it, and the next command goes through. A write returns to idle as soon as the back-end reports completion. Commands are accepted only while the machine is idle and the channel is enabled. Any other command is dropped and raises a sticky error bit.

Top module: `regcmd_chan`

## Requirements
- R1: After reset the state field is idle (0), and the status word reads 0x0010_0000: only sync-idle is set, with read data, pending, init-done and error all 0.
- R2: A command with bit 31 = 1 is a write and with bit 31 = 0 is a read. Bits 30:16 drive `be_addr` (the halfword index) and bits 15:0 drive `be_wdata`. These outputs and `be_write` stay steady while `be_req` waits for `be_ack`.
- R3: Status bits 18:16 carry the state: idle = 0, request = 2, waiting for back-end data = 4, wait-for-valid-clear = 6. Bit 19 is 1 exactly while the request is pending (state 2).
- R4: A read finishes in state 6 with the returned data in status bits 15:0. The state and the data hold there for as long as no valid-clear of 1 is written.
- R5: A write returns to idle on the cycle after back-end completion, with no valid-clear. Status bits 15:0 keep the last read data.
- R6: Writing valid-clear with value 1 in state 6 returns the machine to idle. Writing it with value 0 has no effect.
- R7: A read whose data arrives long after issue still parks in state 6. A valid-clear then frees it, and a command written in the very next cycle is accepted.
- R8: A command written while the state is not idle, or while `chan_en` is 0, is dropped: state and back-end outputs are unchanged. It sets status bit 22, which stays 1 until reset.
- R9: A valid-clear write in any state other than 6 has no effect.
- R10: Status bit 20 (sync-idle) is 1 in states 0 and 6 and 0 while a transfer is in flight (states 2 and 4).
- R11: Status bit 21 (init-done) takes the value of `init_val` on the cycle after `init_wr`, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel enable; commands are dropped while 0 |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command: bit 31 write flag, 30:16 halfword address, 15:0 write data |
| vclr_wr | input | 1 | Valid-clear register write strobe |
| vclr_val | input | 1 | Value written to valid-clear |
| init_wr | input | 1 | Init-done register write strobe |
| init_val | input | 1 | Value written to init-done |
| be_req | output | 1 | Request to the serial back-end |
| be_write | output | 1 | Request is a write |
| be_addr | output | 15 | Halfword register address |
| be_wdata | output | 16 | Write data |
| be_ack | input | 1 | Back-end has taken the request |
| be_done | input | 1 | Back-end transfer complete, read data valid |
| be_rdata | input | 16 | Read data from the back-end |
| status_word | output | 32 | Packed status: data, state, pending, sync-idle, init-done, error |

## Verification
Seeded random transactions mix reads and writes with random addresses, data, acknowledge delays and completion delays. They tell apart the read path, which must park in state 6 and keep its data, from the write path, which must return straight to idle and leave the data field alone. Directed cases hold a read's completion back for dozens of cycles and inject commands and valid-clears during that wait. They show that only a clear with value 1, in state 6, frees the machine, and that a following command is accepted at once. Further cases drop commands with the channel disabled, separating the sticky error from normal flow, and toggle the init-done register independently of any transfer.

// File: rtl/regcmd_pkg.sv
// Package: shared state encoding and status bit positions for the
// register command channel. The state codes are read by software through
// the status word, so their values are fixed.
package regcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd4,
        ST_VCLR = 3'd6
    } chan_state_e;

    localparam int STATE_W = 3;

endpackage

// File: rtl/regcmd_decode.sv
// Module: regcmd_decode
// Splits a command word into direction, halfword address and write data.
// Assumes the word is {write_flag, address, data} with data in the LSBs.
module regcmd_decode #(
    parameter  int DATA_W = 16,
    parameter  int ADDR_W = 15,
    localparam int CMD_W  = 1 + ADDR_W + DATA_W
) (
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              is_write,
    output logic [ADDR_W-1:0] hw_addr,
    output logic [DATA_W-1:0] wdata
);

    // Field extraction, purely combinational.
    always_comb begin
        is_write = cmd_word[CMD_W-1];
        hw_addr  = cmd_word[DATA_W +: ADDR_W];
        wdata    = cmd_word[DATA_W-1:0];
    end

endmodule

// File: rtl/regcmd_fsm.sv
// Module: regcmd_fsm
// Command state machine: accepts a decoded command while idle and enabled,
// requests the back-end, waits for completion, and for reads parks until a
// valid-clear of 1. Flags dropped commands in a sticky bit.
// Assumes be_ack is only meaningful in the request state and be_done only
// in the wait state.
module regcmd_fsm
    import regcmd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chan_en,
    input  logic               cmd_wr,
    input  logic               dec_write,
    input  logic [ADDR_W-1:0]  dec_addr,
    input  logic [DATA_W-1:0]  dec_wdata,
    input  logic               vclr_wr,
    input  logic               vclr_val,
    input  logic               be_ack,
    input  logic               be_done,
    input  logic [DATA_W-1:0]  be_rdata,
    output logic               be_req,
    output logic               be_write,
    output logic [ADDR_W-1:0]  be_addr,
    output logic [DATA_W-1:0]  be_wdata,
    output logic [STATE_W-1:0] state_code,
    output logic [DATA_W-1:0]  rd_hold,
    output logic               drop_err
);

    chan_state_e       state_q;
    logic              op_wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;
    logic              err_q;
    logic              accept;
    logic              clear_hit;

    assign accept    = cmd_wr && chan_en && (state_q == ST_IDLE);
    assign clear_hit = vclr_wr && vclr_val;

    // State transitions of the command channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept)    state_q <= ST_REQ;
                ST_REQ:  if (be_ack)    state_q <= ST_WAIT;
                ST_WAIT: if (be_done)   state_q <= op_wr_q ? ST_IDLE : ST_VCLR;
                ST_VCLR: if (clear_hit) state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the command fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_wr_q <= dec_write;
            addr_q  <= dec_addr;
            wdata_q <= dec_wdata;
        end
    end

    // Hold read data from a completed read until the next read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (state_q == ST_WAIT && be_done && !op_wr_q) begin
            rd_q <= be_rdata;
        end
    end

    // Sticky flag for commands dropped by the idle/enable gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (cmd_wr && !accept) begin
            err_q <= 1'b1;
        end
    end

    assign be_req     = (state_q == ST_REQ);
    assign be_write   = op_wr_q;
    assign be_addr    = addr_q;
    assign be_wdata   = wdata_q;
    assign state_code = state_q;
    assign rd_hold    = rd_q;
    assign drop_err   = err_q;

    // R2: request fields stay steady until acknowledged
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_write) && $stable(be_wdata)));

    // R4: parked read holds state and data until a clear of 1
    assert_vclr_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VCLR && !(vclr_wr && vclr_val)) |=> (state_q == ST_VCLR && $stable(rd_hold)));

    // R5: a write completion goes straight to idle
    assert_write_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && be_done && op_wr_q) |=> (state_q == ST_IDLE));

    // R8: the request state is entered only from idle
    assert_accept_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT || state_q == ST_VCLR) |=> (state_q != ST_REQ));

    // R9: a clear cannot move the machine out of the wait state
    assert_wait_ignores_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !be_done) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/regcmd_status.sv
// Module: regcmd_status
// Holds the software-set init-done bit and packs the status word:
// data in the low DATA_W bits, then state, pending, sync-idle, init-done,
// sticky error. Assumes STAT_W leaves room for DATA_W + 7 bits.
module regcmd_status
    import regcmd_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int STAT_W = 32,
    localparam int FSM_LSB  = DATA_W,
    localparam int PEND_BIT = DATA_W + STATE_W,
    localparam int SYNC_BIT = PEND_BIT + 1,
    localparam int INIT_BIT = PEND_BIT + 2,
    localparam int ERR_BIT  = PEND_BIT + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_wr,
    input  logic               init_val,
    input  logic [STATE_W-1:0] state_code,
    input  logic [DATA_W-1:0]  rd_hold,
    input  logic               drop_err,
    output logic [STAT_W-1:0]  status_word
);

    logic init_q;

    // Software-written init-done register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b0;
        end else if (init_wr) begin
            init_q <= init_val;
        end
    end

    // Pack every field into the status word.
    always_comb begin
        status_word                         = '0;
        status_word[DATA_W-1:0]             = rd_hold;
        status_word[FSM_LSB +: STATE_W]     = state_code;
        status_word[PEND_BIT]               = (state_code == ST_REQ);
        status_word[SYNC_BIT]               = (state_code == ST_IDLE) || (state_code == ST_VCLR);
        status_word[INIT_BIT]               = init_q;
        status_word[ERR_BIT]                = drop_err;
    end

    // R11: init-done follows the register write one cycle later
    assert_init_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (status_word[INIT_BIT] == $past(init_val)));

endmodule

// File: rtl/regcmd_chan.sv
// Module: regcmd_chan (top)
// Register access command channel: decode, state machine and status packing.
// Assumes a single host writer and a back-end that acknowledges a request
// once and later pulses completion once.
module regcmd_chan
    import regcmd_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int ADDR_W = 15,
    parameter  int STAT_W = 32,
    localparam int CMD_W  = 1 + ADDR_W + DATA_W,
    localparam int ERR_BIT = DATA_W + STATE_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              vclr_wr,
    input  logic              vclr_val,
    input  logic              init_wr,
    input  logic              init_val,
    output logic              be_req,
    output logic              be_write,
    output logic [ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_ack,
    input  logic              be_done,
    input  logic [DATA_W-1:0] be_rdata,
    output logic [STAT_W-1:0] status_word
);

    logic               dec_write;
    logic [ADDR_W-1:0]  dec_addr;
    logic [DATA_W-1:0]  dec_wdata;
    logic [STATE_W-1:0] state_code;
    logic [DATA_W-1:0]  rd_hold;
    logic               drop_err;

    regcmd_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .cmd_word (cmd_word),
        .is_write (dec_write),
        .hw_addr  (dec_addr),
        .wdata    (dec_wdata)
    );

    regcmd_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .cmd_wr     (cmd_wr),
        .dec_write  (dec_write),
        .dec_addr   (dec_addr),
        .dec_wdata  (dec_wdata),
        .vclr_wr    (vclr_wr),
        .vclr_val   (vclr_val),
        .be_ack     (be_ack),
        .be_done    (be_done),
        .be_rdata   (be_rdata),
        .be_req     (be_req),
        .be_write   (be_write),
        .be_addr    (be_addr),
        .be_wdata   (be_wdata),
        .state_code (state_code),
        .rd_hold    (rd_hold),
        .drop_err   (drop_err)
    );

    regcmd_status #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_wr     (init_wr),
        .init_val    (init_val),
        .state_code  (state_code),
        .rd_hold     (rd_hold),
        .drop_err    (drop_err),
        .status_word (status_word)
    );

    // R8: a command refused by the gate raises the error bit
    assert_drop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (status_word[DATA_W +: STATE_W] != ST_IDLE || !chan_en)) |=> status_word[ERR_BIT]);

    // R8: the error bit never falls outside reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[ERR_BIT] |=> status_word[ERR_BIT]);

endmodule

// File: tb/regcmd_chan_bench.sv
module regcmd_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        vclr_wr = 1'b0;
    logic        vclr_val = 1'b0;
    logic        init_wr = 1'b0;
    logic        init_val = 1'b0;
    logic        be_req;
    logic        be_write;
    logic [14:0] be_addr;
    logic [15:0] be_wdata;
    logic        be_ack = 1'b0;
    logic        be_done = 1'b0;
    logic [15:0] be_rdata = '0;
    logic [31:0] status_word;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Model of software-visible state
    logic [15:0] m_rd = '0;
    logic        m_init = 1'b0;
    logic        m_err = 1'b0;

    always #10 clk = ~clk;

    regcmd_chan u_regcmd_chan (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .vclr_wr(vclr_wr), .vclr_val(vclr_val),
        .init_wr(init_wr), .init_val(init_val), .be_req(be_req),
        .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_ack(be_ack), .be_done(be_done), .be_rdata(be_rdata),
        .status_word(status_word)
    );

    function automatic logic [31:0] exp_stat(input logic [2:0] st);
        logic [31:0] s;
        s        = '0;
        s[15:0]  = m_rd;
        s[18:16] = st;
        s[19]    = (st == 3'd2);
        s[20]    = (st == 3'd0) || (st == 3'd6);
        s[21]    = m_init;
        s[22]    = m_err;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [2:0] st);
        chk(req, status_word, exp_stat(st));
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue(input logic wr, input logic [15:0] addr, input logic [15:0] data);
        cmd_word = {wr, addr[15:1], data};
        cmd_wr   = 1'b1;
        tick();
        cmd_wr   = 1'b0;
    endtask

    // Full transaction with back-end model; read is left parked unless clr.
    task automatic txn(input logic wr, input logic [15:0] addr, input logic [15:0] data,
                       input int ack_lat, input int done_lat, input logic [15:0] rv,
                       input bit do_clr);
        issue(wr, addr, data);
        chk("R3 request state", status_word, exp_stat(3'd2));
        chk("R2 be_req", {31'd0, be_req}, 32'd1);
        chk("R2 direction", {31'd0, be_write}, {31'd0, wr});
        chk("R2 address", {17'd0, be_addr}, {17'd0, addr[15:1]});
        chk("R2 wdata", {16'd0, be_wdata}, {16'd0, data});
        for (int i = 0; i < ack_lat; i++) begin
            tick();
            chk("R2 hold addr", {17'd0, be_addr}, {17'd0, addr[15:1]});
        end
        be_ack = 1'b1;
        tick();
        be_ack = 1'b0;
        chk_stat("R10 wait state in flight", 3'd4);
        for (int i = 0; i < done_lat; i++) tick();
        be_done  = 1'b1;
        be_rdata = rv;
        tick();
        be_done  = 1'b0;
        be_rdata = $urandom;
        if (wr) begin
            chk_stat("R5 write back to idle", 3'd0);
        end else begin
            m_rd = rv;
            chk_stat("R4 read parked with data", 3'd6);
            if (do_clr) begin
                vclr_wr = 1'b1; vclr_val = 1'b1;
                tick();
                vclr_wr = 1'b0; vclr_val = 1'b0;
                chk_stat("R6 clear returns idle", 3'd0);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        // R1 reset state
        chk_stat("R1 reset status", 3'd0);
        chk("R1 reset value", status_word, 32'h0010_0000);
        rst_n = 1'b1;
        chan_en = 1'b1;
        tick();

        // Directed read and write
        txn(1'b0, 16'hbc0a, 16'h0000, 0, 0, 16'h5aa5, 1'b1);
        txn(1'b1, 16'hbc0c, 16'ha55a, 2, 3, 16'hdead, 1'b1);
        chk("R5 data kept after write", {16'd0, status_word[15:0]}, 32'h0000_5aa5);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            txn(1'($urandom), 16'($urandom), 16'($urandom),
                int'($urandom % 5), int'($urandom % 6), 16'($urandom), 1'b1);
        end

        // R11 init-done register
        init_wr = 1'b1; init_val = 1'b1;
        tick();
        init_wr = 1'b0; m_init = 1'b1;
        chk_stat("R11 init set", 3'd0);
        init_val = 1'b0;
        repeat (3) tick();
        chk_stat("R11 init holds", 3'd0);

        // R9 clear in idle has no effect
        vclr_wr = 1'b1; vclr_val = 1'b1;
        tick();
        vclr_wr = 1'b0; vclr_val = 1'b0;
        chk_stat("R9 clear in idle ignored", 3'd0);

        // Late response: read whose data arrives much later
        issue(1'b0, 16'h1234, 16'h0);
        be_ack = 1'b1;
        tick();
        be_ack = 1'b0;
        chk_stat("R3 wait state", 3'd4);
        vclr_wr = 1'b1; vclr_val = 1'b1;
        tick();
        vclr_wr = 1'b0; vclr_val = 1'b0;
        chk_stat("R9 clear in wait ignored", 3'd4);
        issue(1'b1, 16'h4444, 16'hbeef);
        m_err = 1'b1;
        chk_stat("R8 command dropped in wait", 3'd4);
        chk("R8 address unchanged", {17'd0, be_addr}, {17'd0, 15'h091a});
        repeat (40) tick();
        be_done = 1'b1; be_rdata = 16'h0c3c;
        tick();
        be_done = 1'b0;
        m_rd = 16'h0c3c;
        chk_stat("R7 late data parks", 3'd6);
        repeat (20) tick();
        chk_stat("R4 parked read holds", 3'd6);
        issue(1'b0, 16'h2222, 16'h0);
        chk_stat("R8 command dropped while parked", 3'd6);
        vclr_wr = 1'b1; vclr_val = 1'b0;
        tick();
        vclr_wr = 1'b0;
        chk_stat("R6 clear of zero ignored", 3'd6);
        vclr_wr = 1'b1; vclr_val = 1'b1;
        tick();
        vclr_wr = 1'b0; vclr_val = 1'b0;
        chk_stat("R7 recovered to idle", 3'd0);
        txn(1'b0, 16'h0100, 16'h0, 1, 1, 16'h7e57, 1'b1);
        chk("R7 next command completes", {16'd0, status_word[15:0]}, 32'h0000_7e57);

        // R8 disabled channel
        chan_en = 1'b0;
        issue(1'b1, 16'h0002, 16'h1111);
        chk_stat("R8 dropped while disabled", 3'd0);
        chk("R8 no request while disabled", {31'd0, be_req}, 32'd0);
        chan_en = 1'b1;
        txn(1'b1, 16'h0008, 16'h2468, 0, 0, 16'h0, 1'b0);
        chk_stat("R8 error sticky after good command", 3'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule